// File: doc/BRIEF.md
# Fallback Boot Image Selector

This block stands in for the part of a configuration engine that decides which bitstream a device fetches from serial flash. A header stream of 32-bit words is scanned. Every word is discarded until the synchronisation pattern appears. After that, each word is read as a register-write packet. Its upper half is a command code and its lower half is a 16-bit payload. Four sticky registers collect two image locations, a primary one and a golden one. Each location is a 24-bit flash start address plus the flash read-command byte that goes with it.

A reboot request begins a load attempt. Both kinds of failure add one to a strike counter and start a fresh attempt:

- a CRC error reported by the loader;
- the loader not reporting the sync pattern within a set number of cycles, which is what erased, all-ones flash produces.

While the counter is low, the primary location is presented. Once the counter reaches the primary retry budget, the golden location is presented instead. When every allowed attempt is used up, the block parks in a sticky failure state. A successful load leaves the strike count where it is and shows which image was used. A reboot request keeps the registers and the count. Only a full reset clears them.

Top module: `boot_image_selector`

## Requirements
- R1: After reset, `strike_cnt` is 0, `start_addr` and `read_cmd` are 0, and `loading`, `boot_ok` and `boot_fail` are low.
- R2: Header words are ignored until the word 0xAA995566 has been received. This includes all-ones dummy words and any word whose upper half is a write code. Decoding starts with the word that follows the sync word. Reset returns the parser to the hunting state.
- R3: Once synced, the upper half of a word selects the register and the lower half is written. 0x3261 writes register 1, 0x3281 writes register 2, 0x32A1 writes register 3 and 0x32C1 writes register 4. Any other upper half, including the no-op pair 0x20002000 and a repeated sync word, changes nothing.
- R4: The primary location is an address of {reg2[7:0], reg1[15:0]} with read command reg2[15:8]. The golden location is formed the same way from registers 4 and 3. The chosen location appears on `start_addr`/`read_cmd` in the cycle after the register write.
- R5: A reboot request from idle or from the loaded state raises `loading` on the next cycle. While `strike_cnt` is below 3, the outputs show the primary location.
- R6: A CRC error strobe during a load raises `strike_cnt` by one on the next cycle and starts a new attempt, with `loading` staying high.
- R7: If no sync strobe arrives during an attempt, the attempt fails on its SYNC_LIMIT-th cycle and `strike_cnt` rises by one. A sync strobe seen earlier in the attempt stops this timeout.
- R8: While `strike_cnt` is 3, 4 or 5, the outputs show the golden location and `boot_golden` is high.
- R9: The failure that brings `strike_cnt` to 6 drops `loading` and raises `boot_fail`. `boot_fail` stays high, and reboot requests are ignored, until reset.
- R10: A done strobe during a load with no CRC error in the same cycle raises `boot_ok` on the next cycle, drops `loading`, and keeps `strike_cnt` unchanged. A done strobe together with a CRC error counts as a failure.
- R11: A reboot request leaves the general registers and `strike_cnt` unchanged. Reset clears both.
- R12: CRC error and done strobes have no effect outside a load attempt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high full reset |
| hdr_valid | input | 1 | Header word strobe |
| hdr_word | input | 32 | Header stream word |
| reboot_req | input | 1 | Request to start loading |
| load_sync | input | 1 | Loader saw the sync word in the image |
| load_crc_err | input | 1 | Loader reports a CRC error |
| load_done | input | 1 | Loader reports completion |
| start_addr | output | 24 | Flash start address of the selected image |
| read_cmd | output | 8 | Flash read command of the selected image |
| strike_cnt | output | 3 | Failed attempts since reset |
| loading | output | 1 | A load attempt is in progress |
| boot_ok | output | 1 | Last attempt completed successfully |
| boot_golden | output | 1 | Golden image is the selected one |
| boot_fail | output | 1 | Attempts exhausted (sticky) |

## Verification
Completion and CRC failure can land on the same clock. The bench drives `load_done` and `load_crc_err` in one cycle on the third attempt. It then expects `boot_ok` to stay low, `loading` to stay high, and `strike_cnt` to step from 2 to 3 with the outputs switching to the golden location. The timeout boundary is also checked to the exact cycle: the count must not have moved one cycle before the limit and must have moved on it.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

    localparam logic [31:0] SYNC_PATTERN = 32'hAA995566;
    localparam logic [31:0] NOP_PAIR     = 32'h20002000;
    localparam int          NUM_GEN      = 4;
    localparam int          GEN_IDX_W    = $clog2(NUM_GEN);

    localparam logic [15:0] WR_GEN1 = 16'h3261;
    localparam logic [15:0] WR_GEN2 = 16'h3281;
    localparam logic [15:0] WR_GEN3 = 16'h32A1;
    localparam logic [15:0] WR_GEN4 = 16'h32C1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_OK,
        ST_FAIL
    } boot_state_e;

    typedef struct packed {
        logic [7:0]  cmd;
        logic [23:0] addr;
    } image_loc_t;

    typedef struct packed {
        logic                 hit;
        logic [GEN_IDX_W-1:0] idx;
    } reg_sel_t;

    function automatic reg_sel_t decode_hdr(input logic [15:0] code);
        reg_sel_t s;
        s.hit = 1'b1;
        s.idx = '0;
        case (code)
            WR_GEN1: s.idx = GEN_IDX_W'(0);
            WR_GEN2: s.idx = GEN_IDX_W'(1);
            WR_GEN3: s.idx = GEN_IDX_W'(2);
            WR_GEN4: s.idx = GEN_IDX_W'(3);
            default: s.hit = 1'b0;
        endcase
        return s;
    endfunction

    function automatic image_loc_t make_loc(input logic [15:0] lo_word,
                                            input logic [15:0] hi_word);
        image_loc_t l;
        l.cmd  = hi_word[15:8];
        l.addr = {hi_word[7:0], lo_word};
        return l;
    endfunction

endpackage

// File: rtl/boot_hdr_parser.sv
module boot_hdr_parser
    import boot_sel_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hdr_valid,
    input  logic [31:0]          hdr_word,
    output logic                 wr_en,
    output logic [GEN_IDX_W-1:0] wr_idx,
    output logic [15:0]          wr_data
);

    logic     synced_q;
    reg_sel_t sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            synced_q <= 1'b0;
        end else if (hdr_valid && hdr_word == SYNC_PATTERN) begin
            synced_q <= 1'b1;
        end
    end

    always_comb begin
        sel     = decode_hdr(hdr_word[31:16]);
        wr_en   = hdr_valid && synced_q && sel.hit;
        wr_idx  = sel.idx;
        wr_data = hdr_word[15:0];
    end

    // R3: the no-op pair never produces a register write
    assert_nop_inert_R3: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && hdr_word == NOP_PAIR) |-> !wr_en);

endmodule

// File: rtl/boot_gen_regs.sv
module boot_gen_regs
    import boot_sel_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [GEN_IDX_W-1:0] wr_idx,
    input  logic [15:0]          wr_data,
    output image_loc_t           primary_loc,
    output image_loc_t           golden_loc
);

    logic [NUM_GEN-1:0][15:0] gen_q;

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                gen_q[g] <= '0;
            end else if (wr_en && wr_idx == GEN_IDX_W'(g)) begin
                gen_q[g] <= wr_data;
            end
        end
    end

    assign primary_loc = make_loc(gen_q[0], gen_q[1]);
    assign golden_loc  = make_loc(gen_q[2], gen_q[3]);

    // R11: contents persist whenever the parser issues no write
    assert_sticky_regs_R11: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(gen_q));

endmodule

// File: rtl/boot_retry_fsm.sv
module boot_retry_fsm
    import boot_sel_pkg::*;
#(
    parameter int SYNC_LIMIT    = 1024,
    parameter int PRIMARY_TRIES = 3,
    parameter int MAX_STRIKES   = 6,
    localparam int STRIKE_W     = $clog2(MAX_STRIKES + 1),
    localparam int TMR_W        = (SYNC_LIMIT > 2) ? $clog2(SYNC_LIMIT) : 1
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                reboot_req,
    input  logic                load_sync,
    input  logic                load_crc_err,
    input  logic                load_done,
    output logic [STRIKE_W-1:0] strike_cnt,
    output logic                loading,
    output logic                boot_ok,
    output logic                boot_fail,
    output logic                use_golden
);

    boot_state_e         st_q;
    logic [STRIKE_W-1:0] strike_q;
    logic [TMR_W-1:0]    timer_q;
    logic                seen_q;
    logic                timed_out;
    logic                attempt_fail;

    always_comb begin
        timed_out    = !seen_q && !load_sync && (timer_q == TMR_W'(SYNC_LIMIT - 1));
        attempt_fail = (st_q == ST_LOAD) && (load_crc_err || timed_out);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            strike_q <= '0;
            timer_q  <= '0;
            seen_q   <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE, ST_OK: begin
                    if (reboot_req) begin
                        st_q    <= ST_LOAD;
                        timer_q <= '0;
                        seen_q  <= 1'b0;
                    end
                end
                ST_LOAD: begin
                    if (attempt_fail) begin
                        strike_q <= strike_q + 1'b1;
                        timer_q  <= '0;
                        seen_q   <= 1'b0;
                        if (strike_q == STRIKE_W'(MAX_STRIKES - 1)) begin
                            st_q <= ST_FAIL;
                        end
                    end else if (load_done) begin
                        st_q <= ST_OK;
                    end else begin
                        if (!seen_q) begin
                            timer_q <= timer_q + 1'b1;
                        end
                        seen_q <= seen_q | load_sync;
                    end
                end
                default: st_q <= ST_FAIL;
            endcase
        end
    end

    assign strike_cnt = strike_q;
    assign loading    = (st_q == ST_LOAD);
    assign boot_ok    = (st_q == ST_OK);
    assign boot_fail  = (st_q == ST_FAIL);
    assign use_golden = (strike_q >= STRIKE_W'(PRIMARY_TRIES));

    // R6: the strike count only ever holds or steps up by one
    assert_strike_step_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (strike_cnt == $past(strike_cnt) ||
                  strike_cnt == $past(strike_cnt) + 1'b1));

    // R9: exhaustion is sticky and reached only at the strike ceiling
    assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        boot_fail |=> boot_fail);
    assert_fail_at_max_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(boot_fail) |-> strike_cnt == STRIKE_W'(MAX_STRIKES));

    // R10: success is only ever entered from a running load
    assert_ok_from_load_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(boot_ok) |-> $past(loading));

    // R11: a reboot request outside a load leaves the count alone
    assert_reboot_keeps_strikes_R11: assert property (@(posedge clk) disable iff (rst)
        (reboot_req && !loading) |=> strike_cnt == $past(strike_cnt));

endmodule

// File: rtl/boot_image_selector.sv
module boot_image_selector
    import boot_sel_pkg::*;
#(
    parameter int SYNC_LIMIT    = 1024,
    parameter int PRIMARY_TRIES = 3,
    parameter int MAX_STRIKES   = 6,
    localparam int STRIKE_W     = $clog2(MAX_STRIKES + 1)
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                hdr_valid,
    input  logic [31:0]         hdr_word,
    input  logic                reboot_req,
    input  logic                load_sync,
    input  logic                load_crc_err,
    input  logic                load_done,
    output logic [23:0]         start_addr,
    output logic [7:0]          read_cmd,
    output logic [STRIKE_W-1:0] strike_cnt,
    output logic                loading,
    output logic                boot_ok,
    output logic                boot_golden,
    output logic                boot_fail
);

    logic                 wr_en;
    logic [GEN_IDX_W-1:0] wr_idx;
    logic [15:0]          wr_data;
    image_loc_t           primary_loc;
    image_loc_t           golden_loc;
    image_loc_t           chosen;
    logic                 use_golden;

    boot_hdr_parser u_parser (
        .clk       (clk),
        .rst       (rst),
        .hdr_valid (hdr_valid),
        .hdr_word  (hdr_word),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    boot_gen_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .primary_loc (primary_loc),
        .golden_loc  (golden_loc)
    );

    boot_retry_fsm #(
        .SYNC_LIMIT    (SYNC_LIMIT),
        .PRIMARY_TRIES (PRIMARY_TRIES),
        .MAX_STRIKES   (MAX_STRIKES)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .reboot_req   (reboot_req),
        .load_sync    (load_sync),
        .load_crc_err (load_crc_err),
        .load_done    (load_done),
        .strike_cnt   (strike_cnt),
        .loading      (loading),
        .boot_ok      (boot_ok),
        .boot_fail    (boot_fail),
        .use_golden   (use_golden)
    );

    assign chosen      = use_golden ? golden_loc : primary_loc;
    assign start_addr  = chosen.addr;
    assign read_cmd    = chosen.cmd;
    assign boot_golden = use_golden;

    // R8: the golden location is presented exactly when golden is selected
    assert_golden_route_R8: assert property (@(posedge clk) disable iff (rst)
        boot_golden |-> (start_addr == golden_loc.addr && read_cmd == golden_loc.cmd));

endmodule

// File: tb/boot_image_selector_tb.sv
module boot_image_selector_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        hdr_valid;
    logic [31:0] hdr_word;
    logic        reboot_req;
    logic        load_sync;
    logic        load_crc_err;
    logic        load_done;
    logic [23:0] start_addr;
    logic [7:0]  read_cmd;
    logic [2:0]  strike_cnt;
    logic        loading;
    logic        boot_ok;
    logic        boot_golden;
    logic        boot_fail;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    boot_image_selector #(.SYNC_LIMIT(LIMIT)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .hdr_valid    (hdr_valid),
        .hdr_word     (hdr_word),
        .reboot_req   (reboot_req),
        .load_sync    (load_sync),
        .load_crc_err (load_crc_err),
        .load_done    (load_done),
        .start_addr   (start_addr),
        .read_cmd     (read_cmd),
        .strike_cnt   (strike_cnt),
        .loading      (loading),
        .boot_ok      (boot_ok),
        .boot_golden  (boot_golden),
        .boot_fail    (boot_fail)
    );

    typedef struct packed {
        logic [31:0] word;
        logic [23:0] addr;
        logic [7:0]  cmd;
    } vec_t;

    // primary location expected after each header word (R2, R3, R4)
    localparam vec_t HDR_VEC [10] = '{
        '{32'hFFFFFFFF, 24'h000000, 8'h00},
        '{32'h32611234, 24'h000000, 8'h00},
        '{32'hAA995566, 24'h000000, 8'h00},
        '{32'h32615678, 24'h005678, 8'h00},
        '{32'h32810340, 24'h405678, 8'h03},
        '{32'h20002000, 24'h405678, 8'h03},
        '{32'h31E1FFFF, 24'h405678, 8'h03},
        '{32'h32A10000, 24'h405678, 8'h03},
        '{32'h32C10301, 24'h405678, 8'h03},
        '{32'hAA995566, 24'h405678, 8'h03}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        hdr_valid    = 1'b0;
        hdr_word     = '0;
        reboot_req   = 1'b0;
        load_sync    = 1'b0;
        load_crc_err = 1'b0;
        load_done    = 1'b0;
    endtask

    task automatic pulse_crc();
        load_crc_err = 1'b1;
        tick();
        load_crc_err = 1'b0;
    endtask

    task automatic pulse_reboot();
        reboot_req = 1'b1;
        tick();
        reboot_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        clear_inputs();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        chk("R1 strike", 32'(strike_cnt), 0);
        chk("R1 addr", 32'(start_addr), 0);
        chk("R1 flags", {loading, boot_ok, boot_fail}, 0);

        // header table walk: R2 R3 R4
        foreach (HDR_VEC[i]) begin
            hdr_valid = 1'b1;
            hdr_word  = HDR_VEC[i].word;
            tick();
            hdr_valid = 1'b0;
            chk($sformatf("R4 addr after word %0d", i), 32'(start_addr), 32'(HDR_VEC[i].addr));
            chk($sformatf("R3 cmd after word %0d", i), 32'(read_cmd), 32'(HDR_VEC[i].cmd));
        end

        // R5 reboot starts a primary load
        pulse_reboot();
        chk("R5 loading", 32'(loading), 1);
        chk("R5 primary addr", 32'(start_addr), 32'h405678);
        chk("R5 golden flag", 32'(boot_golden), 0);

        // R7 sync early keeps the attempt alive past the limit
        load_sync = 1'b1;
        tick();
        load_sync = 1'b0;
        repeat (LIMIT * 2) tick();
        chk("R7 no timeout after sync", 32'(strike_cnt), 0);

        // R6 CRC error retries
        pulse_crc();
        chk("R6 strike", 32'(strike_cnt), 1);
        chk("R6 still loading", 32'(loading), 1);

        // R7 exact timeout boundary
        repeat (LIMIT - 1) tick();
        chk("R7 before limit", 32'(strike_cnt), 1);
        tick();
        chk("R7 at limit", 32'(strike_cnt), 2);

        // R10 done with CRC error in the same cycle counts as failure
        load_done    = 1'b1;
        load_crc_err = 1'b1;
        tick();
        load_done    = 1'b0;
        load_crc_err = 1'b0;
        chk("R10 collision strike", 32'(strike_cnt), 3);
        chk("R10 collision no ok", 32'(boot_ok), 0);
        chk("R10 collision loading", 32'(loading), 1);

        // R8 golden selected at strike 3
        chk("R8 golden flag", 32'(boot_golden), 1);
        chk("R8 golden addr", 32'(start_addr), 32'h010000);
        chk("R8 golden cmd", 32'(read_cmd), 32'h03);

        // R10 clean done
        load_done = 1'b1;
        tick();
        load_done = 1'b0;
        chk("R10 ok", 32'(boot_ok), 1);
        chk("R10 not loading", 32'(loading), 0);
        chk("R10 strike held", 32'(strike_cnt), 3);

        // R12 strobes outside a load
        pulse_crc();
        load_done = 1'b1;
        tick();
        load_done = 1'b0;
        chk("R12 strike unchanged", 32'(strike_cnt), 3);
        chk("R12 still ok", 32'(boot_ok), 1);

        // R11 reboot keeps registers and count
        pulse_reboot();
        chk("R11 strike kept", 32'(strike_cnt), 3);
        chk("R11 golden addr kept", 32'(start_addr), 32'h010000);
        chk("R11 loading", 32'(loading), 1);

        // R9 exhaustion
        pulse_crc();
        pulse_crc();
        chk("R9 strike 5", 32'(strike_cnt), 5);
        chk("R9 loading at 5", 32'(loading), 1);
        pulse_crc();
        chk("R9 strike 6", 32'(strike_cnt), 6);
        chk("R9 fail", 32'(boot_fail), 1);
        chk("R9 stopped", 32'(loading), 0);
        pulse_reboot();
        tick();
        chk("R9 reboot ignored", {loading, boot_fail}, 2'b01);

        // R11 reset clears count and registers; R2 parser re-hunts
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R11 reset strike", 32'(strike_cnt), 0);
        chk("R11 reset fail", 32'(boot_fail), 0);
        chk("R11 reset addr", 32'(start_addr), 0);
        hdr_valid = 1'b1;
        hdr_word  = 32'h32615678;
        tick();
        hdr_valid = 1'b0;
        chk("R2 unsynced after reset", 32'(start_addr), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule